// File: doc/BRIEF.md
# Radix Page Table Walker

This block resolves a 64-bit effective address into a real address by walking a multi-level radix tree held in memory. The caller gives a root table base, the number of index bits used at the root, and the total number of address bits the tree translates. Each directory entry carries the index width and base of the table below it. The walk ends at the first entry marked as a leaf. The bits still untranslated at that point set the page size.

Memory is reached through a 64-bit read port with a request/acknowledge handshake and a single-cycle write strobe. The write strobe is used only to update the reference and change flags of the final entry. The block reports the real address, the page-size exponent, the leaf entry as updated, a two-bit fault cause and a write-permission flag. A one-cycle completion pulse marks the result. Access permission checks and nested translation stages belong to other blocks.

Top module: `ptw_top`

## Requirements
- R1: Before each table access, an index width (root or taken from a directory) below 5 ends the walk with fault bit 0 (bad configuration) set, and no further memory read is issued.
- R2: The entry address at each level is the table base plus 8 times the index. The index is the effective address shifted right by (remaining bits minus index width) and masked to index-width bits.
- R3: A fetched entry whose bit 63 (valid) is clear ends the walk with fault bit 1 (missing entry) set, and nothing is written back.
- R4: After each fetch, the index width is subtracted from the remaining bits. For a valid non-leaf entry, the next index width is entry bits [4:0] and the next base is entry bits [55:8] left in place, with the low byte zero.
- R5: The first valid entry with bit 62 (leaf) set ends the walk. pageShift equals the remaining bits. realAddr is entry bits [55:12] left in place, with the low pageShift bits taken from the effective address.
- R6: On success, leafEntry is the fetched leaf with bit 8 (referenced) set, and with bit 7 (changed) also set when the request is a store.
- R7: The updated leaf is written to its own address with one memWrEn pulse before done, and only if it differs from the fetched value.
- R8: writable is 1 only for a successful store. It is 0 for loads and for every fault.
- R9: A walk that has made 8 fetches without reaching a leaf ends with fault bit 0 set, and no ninth read is issued.
- R10: done is a single-cycle pulse. reqReady is high only while idle, and a request presented while busy is ignored.
- R11: memRdReq stays high with an unchanged memRdAddr until memRdAck is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start a walk (taken only when reqReady) |
| reqReady | output | 1 | Walker idle |
| reqAddr | input | 64 | Effective address |
| reqStore | input | 1 | Access is a store |
| rootBase | input | 64 | Root table base |
| rootNls | input | 5 | Root index width |
| rootSize | input | 7 | Total translated bits |
| memRdReq | output | 1 | Read request |
| memRdAddr | output | 64 | Read address |
| memRdAck | input | 1 | Read data valid |
| memRdData | input | 64 | Read data |
| memWrEn | output | 1 | Write strobe |
| memWrAddr | output | 64 | Write address |
| memWrData | output | 64 | Write data |
| done | output | 1 | Result pulse |
| realAddr | output | 64 | Translated address |
| pageShift | output | 7 | Page size exponent |
| leafEntry | output | 64 | Leaf entry after flag update |
| faultCause | output | 2 | Bit 0 bad configuration, bit 1 missing entry |
| writable | output | 1 | Write permission granted |

## Verification
The assertions rely on three properties of the environment. memRdAck is raised only while memRdReq is high and arrives within bounded time. A request's total size is never smaller than the sum of the index widths along its path, so the remaining-bit count cannot wrap. The tables the bench builds all respect this bound. The bench memory answers reads after a latency that rotates between zero and two cycles. The bench also injects a request while a walk is in flight, to confirm that a busy request is ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ValidBit = 63;
  localparam int LeafBit  = 62;
  localparam int RefBit   = 8;
  localparam int ChgBit   = 7;
  localparam int MinNls   = 5;
  localparam logic [63:0] BaseMask = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [63:0] PageMask = 64'h00FF_FFFF_FFFF_F000;

  typedef struct packed {
    logic accept;
    logic issueAddr;
    logic latchEntry;
    logic descend;
    logic finishLeaf;
    logic faultBad;
    logic faultMissing;
  } ctrl_t;

  typedef struct packed {
    logic nlsTooSmall;
    logic capReached;
    logic entryValid;
    logic entryLeaf;
    logic needWrite;
  } stat_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_FETCH, S_EVAL, S_WRITE, S_DONE
  } state_t;
endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int NLS_W      = 5,
  parameter int SHIFT_W    = 7,
  parameter int MAX_LEVELS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctrl,
  output stat_t              stat,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqStore,
  input  logic [ADDR_W-1:0]  rootBase,
  input  logic [NLS_W-1:0]   rootNls,
  input  logic [SHIFT_W-1:0] rootSize,
  input  logic [ADDR_W-1:0]  memRdData,
  output logic [ADDR_W-1:0]  entryAddr,
  output logic [ADDR_W-1:0]  entry,
  output logic [ADDR_W-1:0]  realAddr,
  output logic [SHIFT_W-1:0] pageShift,
  output logic [1:0]         faultCause,
  output logic               writable
);
  localparam int LVL_W = $clog2(MAX_LEVELS + 1);

  logic [ADDR_W-1:0]  eaQ, baseQ, realQ, entryQ, entryAddrQ;
  logic               storeQ, writableQ;
  logic [NLS_W-1:0]   nlsQ;
  logic [SHIFT_W-1:0] remQ;
  logic [LVL_W-1:0]   levelQ;
  logic [1:0]         faultQ;

  logic [SHIFT_W-1:0] idxShift, remAfter;
  logic [ADDR_W-1:0]  idxMask, idx, entryAddrNext, updated, lowMask;

  always_comb begin
    idxShift      = remQ - SHIFT_W'(nlsQ);
    idxMask       = (ADDR_W'(1) << nlsQ) - ADDR_W'(1);
    idx           = (eaQ >> idxShift) & idxMask;
    entryAddrNext = baseQ + (idx << 3);
    remAfter      = remQ - SHIFT_W'(nlsQ);
    lowMask       = (ADDR_W'(1) << remAfter) - ADDR_W'(1);
    updated       = entryQ | (ADDR_W'(1) << RefBit);
    if (storeQ) updated = updated | (ADDR_W'(1) << ChgBit);
  end

  assign stat.nlsTooSmall = nlsQ < NLS_W'(MinNls);
  assign stat.capReached  = levelQ == LVL_W'(MAX_LEVELS);
  assign stat.entryValid  = entryQ[ValidBit];
  assign stat.entryLeaf   = entryQ[LeafBit];
  assign stat.needWrite   = updated != entryQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaQ <= '0; baseQ <= '0; realQ <= '0; entryQ <= '0; entryAddrQ <= '0;
      storeQ <= 1'b0; writableQ <= 1'b0; nlsQ <= '0; remQ <= '0;
      levelQ <= '0; faultQ <= '0;
    end else begin
      if (ctrl.accept) begin
        eaQ       <= reqAddr;
        storeQ    <= reqStore;
        baseQ     <= rootBase;
        nlsQ      <= rootNls;
        remQ      <= rootSize;
        levelQ    <= '0;
        faultQ    <= '0;
        writableQ <= 1'b0;
        realQ     <= '0;
      end
      if (ctrl.issueAddr) entryAddrQ <= entryAddrNext;
      if (ctrl.latchEntry) begin
        entryQ <= memRdData;
        levelQ <= levelQ + LVL_W'(1);
      end
      if (ctrl.descend) begin
        remQ  <= remAfter;
        nlsQ  <= entryQ[NLS_W-1:0];
        baseQ <= entryQ & BaseMask;
      end
      if (ctrl.finishLeaf) begin
        remQ      <= remAfter;
        entryQ    <= updated;
        realQ     <= (entryQ & PageMask & ~lowMask) | (eaQ & lowMask);
        writableQ <= storeQ;
      end
      if (ctrl.faultBad)     faultQ[0] <= 1'b1;
      if (ctrl.faultMissing) faultQ[1] <= 1'b1;
    end
  end

  assign entryAddr  = entryAddrQ;
  assign entry      = entryQ;
  assign realAddr   = realQ;
  assign pageShift  = remQ;
  assign faultCause = faultQ;
  assign writable   = writableQ;

  // R9: the fetch counter never passes the level cap
  a_r9_level_cap: assert property (@(posedge clk) disable iff (!rstN)
    levelQ <= LVL_W'(MAX_LEVELS));
endmodule

// File: rtl/ptw_control.sv
module ptw_control
  import ptw_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqValid,
  input  logic  memRdAck,
  input  stat_t stat,
  output ctrl_t ctrl,
  output logic  reqReady,
  output logic  memRdReq,
  output logic  memWrEn,
  output logic  done
);
  state_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    ctrl   = '0;
    case (stateQ)
      S_IDLE: if (reqValid) begin
        ctrl.accept = 1'b1;
        stateD = S_ADDR;
      end
      S_ADDR: begin
        if (stat.nlsTooSmall || stat.capReached) begin
          ctrl.faultBad = 1'b1;
          stateD = S_DONE;
        end else begin
          ctrl.issueAddr = 1'b1;
          stateD = S_FETCH;
        end
      end
      S_FETCH: if (memRdAck) begin
        ctrl.latchEntry = 1'b1;
        stateD = S_EVAL;
      end
      S_EVAL: begin
        if (!stat.entryValid) begin
          ctrl.faultMissing = 1'b1;
          stateD = S_DONE;
        end else if (stat.entryLeaf) begin
          ctrl.finishLeaf = 1'b1;
          stateD = stat.needWrite ? S_WRITE : S_DONE;
        end else begin
          ctrl.descend = 1'b1;
          stateD = S_ADDR;
        end
      end
      S_WRITE: stateD = S_DONE;
      S_DONE:  stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady = stateQ == S_IDLE;
  assign memRdReq = stateQ == S_FETCH;
  assign memWrEn  = stateQ == S_WRITE;
  assign done     = stateQ == S_DONE;

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10: an accepted request makes the walker busy
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);
  // R7: a write-back is followed directly by completion
  a_r7_write_then_done: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> done);
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int NLS_W      = 5,
  parameter int SHIFT_W    = 7,
  parameter int MAX_LEVELS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqStore,
  input  logic [ADDR_W-1:0]  rootBase,
  input  logic [NLS_W-1:0]   rootNls,
  input  logic [SHIFT_W-1:0] rootSize,
  output logic               memRdReq,
  output logic [ADDR_W-1:0]  memRdAddr,
  input  logic               memRdAck,
  input  logic [ADDR_W-1:0]  memRdData,
  output logic               memWrEn,
  output logic [ADDR_W-1:0]  memWrAddr,
  output logic [ADDR_W-1:0]  memWrData,
  output logic               done,
  output logic [ADDR_W-1:0]  realAddr,
  output logic [SHIFT_W-1:0] pageShift,
  output logic [ADDR_W-1:0]  leafEntry,
  output logic [1:0]         faultCause,
  output logic               writable
);
  ctrl_t             ctrl;
  stat_t             stat;
  logic [ADDR_W-1:0] entryAddr, entry;

  ptw_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRdAck(memRdAck),
    .stat(stat), .ctrl(ctrl), .reqReady(reqReady), .memRdReq(memRdReq),
    .memWrEn(memWrEn), .done(done)
  );

  ptw_datapath #(
    .ADDR_W(ADDR_W), .NLS_W(NLS_W), .SHIFT_W(SHIFT_W), .MAX_LEVELS(MAX_LEVELS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .stat(stat), .reqAddr(reqAddr),
    .reqStore(reqStore), .rootBase(rootBase), .rootNls(rootNls),
    .rootSize(rootSize), .memRdData(memRdData), .entryAddr(entryAddr),
    .entry(entry), .realAddr(realAddr), .pageShift(pageShift),
    .faultCause(faultCause), .writable(writable)
  );

  assign memRdAddr = entryAddr;
  assign memWrAddr = entryAddr;
  assign memWrData = entry;
  assign leafEntry = entry;

  // R11: a pending read holds its request and address
  a_r11_hold_read: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && !memRdAck |=> memRdReq && $stable(memRdAddr));
  // R6: a clean result carries a referenced leaf
  a_r6_ref_set: assert property (@(posedge clk) disable iff (!rstN)
    done && faultCause == 2'b00 |-> leafEntry[RefBit] && leafEntry[LeafBit]);
  // R8: no write permission on a faulted walk
  a_r8_no_perm_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    done && faultCause != 2'b00 |-> !writable);
endmodule

// File: tb/tb_ptw_top.sv
module tb_ptw_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqAddr = '0;
  logic        reqStore = 1'b0;
  logic [63:0] rootBase = '0;
  logic [4:0]  rootNls = '0;
  logic [6:0]  rootSize = '0;
  logic        memRdReq;
  logic [63:0] memRdAddr;
  logic        memRdAck = 1'b0;
  logic [63:0] memRdData = '0;
  logic        memWrEn;
  logic [63:0] memWrAddr, memWrData;
  logic        done;
  logic [63:0] realAddr, leafEntry;
  logic [6:0]  pageShift;
  logic [1:0]  faultCause;
  logic        writable;

  always #5 clk = ~clk;

  ptw_top dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqStore(reqStore), .rootBase(rootBase),
    .rootNls(rootNls), .rootSize(rootSize), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .memRdAck(memRdAck), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .done(done), .realAddr(realAddr), .pageShift(pageShift),
    .leafEntry(leafEntry), .faultCause(faultCause), .writable(writable)
  );

  logic [63:0] mem [logic [63:0]];
  int checks = 0, fails = 0;
  int rdCount = 0, wrCount = 0, waitCnt = 0, latSel = 0;
  logic        expWr = 1'b0;
  logic [63:0] expWrAddr = '0, expWrData = '0;

  localparam logic [63:0] V = 64'h8000_0000_0000_0000;
  localparam logic [63:0] L = 64'h4000_0000_0000_0000;

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder and per-cycle write comparison
  always @(negedge clk) begin
    if (memWrEn) begin
      wrCount++;
      check(expWr && memWrAddr == expWrAddr, "R7", "write address", memWrAddr, expWrAddr);
      check(memWrData == expWrData, "R7", "write data", memWrData, expWrData);
      mem[memWrAddr] = memWrData;
    end
    if (memRdAck) memRdAck = 1'b0;
    else if (memRdReq) begin
      if (waitCnt == 0) begin
        memRdAck  = 1'b1;
        memRdData = rd(memRdAddr);
        rdCount++;
        waitCnt = latSel % 3;
        latSel++;
      end else waitCnt--;
    end
  end

  // behavioural reference walk
  task automatic ref_walk(input logic [63:0] ea, input bit st, input logic [63:0] base,
                          input int nls0, input int size,
                          output logic [63:0] eReal, output int eShift,
                          output logic [63:0] eEntry, output logic [1:0] eFault,
                          output bit eWrb, output int eFetch,
                          output bit eWr, output logic [63:0] eWrA, output logic [63:0] eWrD);
    int nls = nls0, rem = size, lvl = 0;
    logic [63:0] b = base, a, e, upd, m;
    eReal = 0; eShift = 0; eEntry = 0; eFault = 0; eWrb = 0; eWr = 0; eWrA = 0; eWrD = 0;
    forever begin
      if (nls < 5 || lvl == 8) begin eFault = 2'b01; break; end
      a = b + (((ea >> (rem - nls)) & ((64'd1 << nls) - 1)) * 8);
      e = rd(a);
      lvl++;
      if (!e[63]) begin eFault = 2'b10; break; end
      rem -= nls;
      if (e[62]) begin
        upd = e | 64'h100 | (st ? 64'h80 : 64'h0);
        m = (64'd1 << rem) - 1;
        eReal = (e & 64'h00FF_FFFF_FFFF_F000 & ~m) | (ea & m);
        eShift = rem; eEntry = upd; eWrb = st;
        eWr = (upd != e); eWrA = a; eWrD = upd;
        break;
      end
      nls = int'(e[4:0]);
      b = e & 64'h00FF_FFFF_FFFF_FF00;
    end
    eFetch = lvl;
  endtask

  // builds one path of entries down a tree
  task automatic mk_path(input logic [63:0] tbase, input logic [63:0] ea, input int size,
                         input int n0, input int n1, input int n2, input int n3,
                         input int nLev, input logic [63:0] leaf);
    int ns[4];
    int rem = size;
    ns[0] = n0; ns[1] = n1; ns[2] = n2; ns[3] = n3;
    for (int k = 0; k < nLev; k++) begin
      logic [63:0] b = tbase + 64'(k) * 64'h10_0000;
      logic [63:0] a = b + (((ea >> (rem - ns[k])) & ((64'd1 << ns[k]) - 1)) * 8);
      rem -= ns[k];
      if (k == nLev - 1) mem[a] = V | L | leaf;
      else mem[a] = V | (b + 64'h10_0000) | 64'(ns[k+1]);
    end
  endtask

  task automatic walk(input string tag, input logic [63:0] ea, input bit st,
                      input logic [63:0] base, input int nls, input int size, input bit poke);
    logic [63:0] eReal, eEntry, eWrA, eWrD;
    int eShift, eFetch, cyc;
    logic [1:0] eFault;
    bit eWrb, eWr;
    ref_walk(ea, st, base, nls, size, eReal, eShift, eEntry, eFault, eWrb, eFetch, eWr, eWrA, eWrD);
    expWr = eWr; expWrAddr = eWrA; expWrData = eWrD;
    rdCount = 0; wrCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = ea; reqStore = st; rootBase = base;
    rootNls = 5'(nls); rootSize = 7'(size);
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R10", {tag, " busy after accept"}, 64'(reqReady), 0);
    cyc = 0;
    while (!done && cyc < 500) begin
      if (poke && cyc == 2) begin
        reqValid = 1'b1; reqAddr = ~ea; reqStore = ~st; rootNls = 5'd31;
      end else reqValid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    reqValid = 1'b0;
    check(done, "R10", {tag, " completion seen"}, 64'(done), 1);
    check(faultCause == eFault, "R1/R3/R9", {tag, " fault"}, 64'(faultCause), 64'(eFault));
    check(rdCount == eFetch, "R2", {tag, " fetch count"}, 64'(rdCount), 64'(eFetch));
    check(writable == eWrb, "R8", {tag, " writable"}, 64'(writable), 64'(eWrb));
    if (eFault == 0) begin
      check(realAddr == eReal, "R5", {tag, " real address"}, realAddr, eReal);
      check(pageShift == 7'(eShift), "R5", {tag, " page shift"}, 64'(pageShift), 64'(eShift));
      check(leafEntry == eEntry, "R6", {tag, " leaf entry"}, leafEntry, eEntry);
    end
    check(wrCount == (eWr ? 1 : 0), "R7", {tag, " write count"}, 64'(wrCount), 64'(eWr));
    @(negedge clk);
    check(!done, "R10", {tag, " done one cycle"}, 64'(done), 0);
    check(reqReady, "R10", {tag, " idle again"}, 64'(reqReady), 1);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] eaA = 64'h0000_0ABC_DEF1_2345;
    logic [63:0] eaB = 64'h000F_F3C0_1234_5678;
    repeat (3) @(negedge clk);
    check(reqReady && !done && !memRdReq && !memWrEn, "R10", "reset state",
          {60'd0, reqReady, done, memRdReq, memWrEn}, 64'h8);
    rstN = 1'b1;
    @(negedge clk);
    // four-level tree, 4 KiB leaf
    mk_path(64'h0010_0000, eaA, 52, 13, 9, 9, 9, 4, 64'h0000_0076_5432_1000);
    walk("R5 load 4lvl", eaA, 1'b0, 64'h0010_0000, 13, 52, 1'b0);
    walk("R6 store sets C", eaA, 1'b1, 64'h0010_0000, 13, 52, 1'b0);
    walk("R7 store no change", eaA, 1'b1, 64'h0010_0000, 13, 52, 1'b0);
    walk("R8 load no change", eaA, 1'b0, 64'h0010_0000, 13, 52, 1'b0);
    // two-level tree, large page with R preset
    mk_path(64'h0100_0000, eaB, 52, 13, 9, 0, 0, 2, 64'h0000_0123_C000_0100);
    walk("R4 large page", eaB, 1'b0, 64'h0100_0000, 13, 52, 1'b0);
    walk("R10 busy poke", eaB, 1'b1, 64'h0100_0000, 13, 52, 1'b1);
    // missing entry below an existing root slot
    walk("R3 missing", eaA ^ 64'h0000_0000_4000_0000, 1'b0, 64'h0010_0000, 13, 52, 1'b0);
    walk("R3 missing root", 64'h0000_0001_0000_0000, 1'b1, 64'h0010_0000, 13, 52, 1'b0);
    // bad root width
    walk("R1 root width", eaA, 1'b0, 64'h0010_0000, 4, 52, 1'b0);
    // directory supplies a too small width
    mk_path(64'h0200_0000, eaA, 52, 13, 3, 9, 0, 3, 64'h0);
    walk("R1 dir width", eaA, 1'b0, 64'h0200_0000, 13, 52, 1'b0);
    // self-referencing directory exceeds the cap
    mem[64'h0900_0000] = V | 64'h0900_0000 | 64'd5;
    walk("R9 level cap", 64'h0, 1'b0, 64'h0900_0000, 5, 60, 1'b0);
    // R11 exercised by rotating latency across all walks above
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule